// File: doc/BRIEF.md
# Ternary-Weight Activation-Stationary Multiply-Accumulate Array

This block is a compact matrix-vector engine for weights restricted to -1, 0 and +1. Weights arrive as a byte stream over a valid/ready handshake. Each byte carries five ternary weights in base-3 form. A small combinational unpacker splits every byte into a zero mask and a negate mask. There is no multiplier: each processing element adds its activation, subtracts it, or leaves its accumulator unchanged.

The array is built from `NUM_SLICES` compute slices of five lanes each. Lane `e` of every slice receives the same unpacked weight. Each element holds its own signed activation, which is loaded once through a parallel load strobe and kept for as many passes as needed. All slices share the one byte stream, so adding slices raises the work done per byte without needing more input bandwidth.

A pass accepts `PASS_LEN` weight bytes. After the last byte, the accumulators become a shift chain. They present one result per accepted handshake on the result port, and zeros are shifted in behind the results. When the last result leaves, a one-cycle done pulse fires and the array is ready for the next pass with the same activations.

Top module: `trit_mac_engine`

## Requirements
- R1: After reset `wReady` is 1, `resValid` is 0 and `done` is 0, and all activations and accumulators are zero.
- R2: In a valid code (0 to 242), base-3 digit `e` (the weight of 3^e) drives lane `e`. Digit 0 means weight 0, digit 1 means +1 and digit 2 means -1. For example, code 1 gives +1 on lane 0 and code 2 gives -1 on lane 0.
- R3: Codes 243 to 255 decode to weight 0 on every lane, so accepting them leaves every accumulator unchanged.
- R4: Element `i = s*5 + e` holds activation `actData[i*ACT_W +: ACT_W]` (signed). Each accepted weight byte adds (lane-`e` weight × activation `i`) to that element's accumulator. The same lane weight is applied in every slice.
- R5: `wReady` is high only while a pass is collecting weights. After exactly `PASS_LEN` accepted bytes, `wReady` drops and `resValid` rises. Results then appear in element order 0, 1, …, `NUM_EL-1`, with one result leaving per cycle in which `resValid` and `resReady` are both high. `wReady` and `resValid` are never high together.
- R6: While `resValid` is high and `resReady` is low, `resData` holds its value.
- R7: `done` is a one-cycle pulse in the cycle after the last result handshake. The next pass then starts from zeroed accumulators with the same activations.
- R8: `actLoad` has priority over everything else. In its cycle it loads every activation, clears every accumulator and restarts a pass, including a pass that is part-way through its drain. `wReady` is low in that cycle, so a byte presented with it is not accepted.
- R9: Accumulators are `ACT_W + clog2(PASS_LEN) + 1` bits signed and never overflow. For example, -128 with weight -1 on all 16 bytes gives +2048, and -128 with weight +1 on all 16 bytes gives -2048.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| actLoad | input | 1 | Load all activations, clear accumulators, restart pass |
| actData | input | NUM_SLICES*5*ACT_W | Signed activations; element i at bits [i*ACT_W +: ACT_W] |
| wValid | input | 1 | Weight byte valid |
| wReady | output | 1 | Weight byte accepted when high with wValid |
| wData | input | 8 | Packed base-3 weight byte |
| resValid | output | 1 | Result valid |
| resReady | input | 1 | Result consumer ready |
| resData | output | ACT_W+clog2(PASS_LEN)+1 | Signed result of the element at the head of the chain |
| done | output | 1 | One-cycle pulse after the last result of a pass |

## Verification
The activation load can land in the same cycle as a weight handshake, or in the same cycle as a result handshake in the middle of a drain. The bench provokes the first case by holding a valid weight byte across the load cycle. It provokes the second by strobing the load with `resReady` high after three results have left. A behavioural per-cycle model judges both cases. The held byte must not be counted, so the pass still needs `PASS_LEN` new bytes. The aborted drain must give way to a fresh pass whose results start from zero.

// File: rtl/trit_mac_pkg.sv
package trit_mac_pkg;
  localparam int LANES      = 5;
  localparam int CODE_W     = 8;
  localparam int MAX_CODE   = 242;

  typedef struct packed {
    logic [LANES-1:0] zero;
    logic [LANES-1:0] neg;
  } tritMask_t;

  typedef struct packed {
    logic loadAct;
    logic accumEn;
    logic shiftEn;
  } ctrlStrobe_t;
endpackage

// File: rtl/trit_unpack.sv
module trit_unpack
  import trit_mac_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output tritMask_t         mask
);
  logic [CODE_W-1:0] quot [LANES+1];
  logic [LANES-1:0]  zeroRaw;
  logic [LANES-1:0]  negRaw;
  logic              codeOk;

  assign quot[0] = code;

  // one base-3 digit per lane, least significant digit on lane 0
  for (genvar e = 0; e < LANES; e++) begin : g_digit
    logic [1:0] digit;
    assign quot[e+1]  = quot[e] / CODE_W'(3);
    assign digit      = 2'(quot[e] - quot[e+1] * CODE_W'(3));
    assign zeroRaw[e] = (digit == 2'd0);
    assign negRaw[e]  = (digit == 2'd2);
  end

  assign codeOk    = (code <= CODE_W'(MAX_CODE));
  assign mask.zero = codeOk ? zeroRaw : '1;
  assign mask.neg  = codeOk ? negRaw  : '0;
endmodule

// File: rtl/trit_mac_ctrl.sv
module trit_mac_ctrl
  import trit_mac_pkg::*;
#(
  parameter int NUM_EL   = 20,
  parameter int PASS_LEN = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        actLoad,
  input  logic        wValid,
  input  logic        resReady,
  output logic        wReady,
  output logic        resValid,
  output logic        done,
  output ctrlStrobe_t strb
);
  localparam int WC_W = $clog2(PASS_LEN + 1);
  localparam int OC_W = $clog2(NUM_EL + 1);

  typedef enum logic {ST_COLLECT, ST_DRAIN} state_t;

  state_t          state;
  logic [WC_W-1:0] wordCnt;
  logic [OC_W-1:0] outCnt;
  logic            wFire;
  logic            rFire;
  logic            lastWord;
  logic            lastOut;

  assign wReady   = (state == ST_COLLECT) && !actLoad;
  assign resValid = (state == ST_DRAIN);
  assign wFire    = wValid && wReady;
  assign rFire    = resValid && resReady && !actLoad;
  assign lastWord = (wordCnt == WC_W'(PASS_LEN - 1));
  assign lastOut  = (outCnt == OC_W'(NUM_EL - 1));

  assign strb.loadAct = actLoad;
  assign strb.accumEn = wFire;
  assign strb.shiftEn = rFire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_COLLECT;
      wordCnt <= '0;
      outCnt  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (actLoad) begin
        state   <= ST_COLLECT;
        wordCnt <= '0;
        outCnt  <= '0;
      end else if (wFire) begin
        if (lastWord) begin
          state   <= ST_DRAIN;
          wordCnt <= '0;
        end else begin
          wordCnt <= wordCnt + WC_W'(1);
        end
      end else if (rFire) begin
        if (lastOut) begin
          state  <= ST_COLLECT;
          outCnt <= '0;
          done   <= 1'b1;
        end else begin
          outCnt <= outCnt + OC_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/trit_mac_datapath.sv
module trit_mac_datapath
  import trit_mac_pkg::*;
#(
  parameter int NUM_SLICES = 4,
  parameter int ACT_W      = 8,
  parameter int ACC_W      = 13
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  ctrlStrobe_t                         strb,
  input  tritMask_t                           mask,
  input  logic [NUM_SLICES*LANES*ACT_W-1:0]   actData,
  output logic [ACC_W-1:0]                    resData
);
  localparam int NUM_EL = NUM_SLICES * LANES;

  logic signed [ACT_W-1:0] actReg  [NUM_EL];
  logic signed [ACC_W-1:0] accReg  [NUM_EL];
  logic signed [ACC_W-1:0] addend  [NUM_EL];
  logic signed [ACC_W-1:0] shiftIn [NUM_EL];

  // broadcast: lane e of every slice uses the same decoded weight
  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    for (genvar e = 0; e < LANES; e++) begin : g_lane
      localparam int IDX = s * LANES + e;
      logic signed [ACC_W-1:0] extAct;
      assign extAct      = ACC_W'(actReg[IDX]);
      assign addend[IDX] = mask.zero[e] ? '0 : (mask.neg[e] ? -extAct : extAct);
    end
  end

  // result chain toward element 0, zeros enter at the tail
  for (genvar i = 0; i < NUM_EL; i++) begin : g_chain
    if (i == NUM_EL - 1) begin : g_tail
      assign shiftIn[i] = '0;
    end else begin : g_link
      assign shiftIn[i] = accReg[i+1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_EL; i++) begin
        actReg[i] <= '0;
        accReg[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_EL; i++) begin
        if (strb.loadAct) begin
          actReg[i] <= actData[i*ACT_W +: ACT_W];
          accReg[i] <= '0;
        end else if (strb.accumEn) begin
          accReg[i] <= accReg[i] + addend[i];
        end else if (strb.shiftEn) begin
          accReg[i] <= shiftIn[i];
        end
      end
    end
  end

  assign resData = accReg[0];
endmodule

// File: rtl/trit_mac_engine.sv
module trit_mac_engine
  import trit_mac_pkg::*;
#(
  parameter int NUM_SLICES = 4,
  parameter int ACT_W      = 8,
  parameter int PASS_LEN   = 16,
  localparam int NUM_EL    = NUM_SLICES * LANES,
  localparam int ACC_W     = ACT_W + $clog2(PASS_LEN) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    actLoad,
  input  logic [NUM_EL*ACT_W-1:0] actData,
  input  logic                    wValid,
  output logic                    wReady,
  input  logic [CODE_W-1:0]       wData,
  output logic                    resValid,
  input  logic                    resReady,
  output logic [ACC_W-1:0]        resData,
  output logic                    done
);
  ctrlStrobe_t strb;
  tritMask_t   mask;

  trit_unpack u_unpack (
    .code (wData),
    .mask (mask)
  );

  trit_mac_ctrl #(
    .NUM_EL   (NUM_EL),
    .PASS_LEN (PASS_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .actLoad  (actLoad),
    .wValid   (wValid),
    .resReady (resReady),
    .wReady   (wReady),
    .resValid (resValid),
    .done     (done),
    .strb     (strb)
  );

  trit_mac_datapath #(
    .NUM_SLICES (NUM_SLICES),
    .ACT_W      (ACT_W),
    .ACC_W      (ACC_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .mask    (mask),
    .actData (actData),
    .resData (resData)
  );
endmodule

// File: rtl/trit_mac_checker.sv
module trit_mac_checker #(
  parameter int RES_W = 13
) (
  input logic             clk,
  input logic             rstN,
  input logic             actLoad,
  input logic             wReady,
  input logic             resValid,
  input logic             resReady,
  input logic             done,
  input logic [RES_W-1:0] resData
);
  p_ready_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(wReady && resValid));

  p_hold_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resReady && !actLoad |=> resValid && $stable(resData));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_resume_r7: assert property (@(posedge clk) disable iff (!rstN)
    done && !actLoad |-> wReady && !resValid);

  p_load_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    actLoad |-> !wReady);

  p_load_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    actLoad |=> !resValid && !done);
endmodule

bind trit_mac_engine trit_mac_checker #(.RES_W($bits(resData))) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .actLoad  (actLoad),
  .wReady   (wReady),
  .resValid (resValid),
  .resReady (resReady),
  .done     (done),
  .resData  (resData)
);

// File: tb/trit_mac_engine_tb_top.sv
`timescale 1ns/1ps
module trit_mac_engine_tb_top;
  localparam int NS = 4;
  localparam int AW = 8;
  localparam int PL = 16;
  localparam int LN = 5;
  localparam int NE = NS * LN;
  localparam int RW = AW + $clog2(PL) + 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rstN = 1'b0;
  logic              actLoad = 1'b0;
  logic [NE*AW-1:0]  actData = '0;
  logic              wValid = 1'b0;
  logic              wReady;
  logic [7:0]        wData = '0;
  logic              resValid;
  logic              resReady = 1'b0;
  logic [RW-1:0]     resData;
  logic              done;

  trit_mac_engine #(.NUM_SLICES(NS), .ACT_W(AW), .PASS_LEN(PL)) dut_i (
    .clk(clk), .rstN(rstN), .actLoad(actLoad), .actData(actData),
    .wValid(wValid), .wReady(wReady), .wData(wData),
    .resValid(resValid), .resReady(resReady), .resData(resData), .done(done)
  );

  int    nChecks = 0;
  int    nErrors = 0;
  string tag = "R1";
  bit    started = 1'b0;
  bit    holdPrev = 1'b0;

  int curT [LN];
  int curAct [NE];

  // behavioural reference model
  bit mRun;
  int mWc;
  int mOc;
  bit mDone;
  int mAcc [NE];
  int mAct [NE];

  task automatic chk(input bit ok, input string req, input string what,
                     input int actV, input int expV);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, actV, expV, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 1'b1; mWc = 0; mOc = 0; mDone = 1'b0;
      for (int i = 0; i < NE; i++) begin mAcc[i] = 0; mAct[i] = 0; end
    end else begin
      mDone = 1'b0;
      if (actLoad) begin
        for (int i = 0; i < NE; i++) begin mAct[i] = curAct[i]; mAcc[i] = 0; end
        mRun = 1'b1; mWc = 0; mOc = 0;
      end else if (mRun) begin
        if (wValid) begin
          for (int i = 0; i < NE; i++) mAcc[i] += curT[i % LN] * mAct[i];
          mWc++;
          if (mWc == PL) begin mRun = 1'b0; mWc = 0; end
        end
      end else if (resReady) begin
        for (int i = 0; i < NE - 1; i++) mAcc[i] = mAcc[i+1];
        mAcc[NE-1] = 0;
        mOc++;
        if (mOc == NE) begin mRun = 1'b1; mOc = 0; mDone = 1'b1; end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always begin
    @(negedge clk);
    #1;
    if (rstN && started) begin
      bit expR;
      expR = mRun && !actLoad;
      chk(wReady == expR, actLoad ? "R8" : "R5", "wReady", int'(wReady), int'(expR));
      chk(resValid == !mRun, "R5", "resValid", int'(resValid), int'(!mRun));
      chk(done == mDone, "R7", "done", int'(done), int'(mDone));
      if (!mRun)
        chk(int'($signed(resData)) == mAcc[0], holdPrev ? "R6" : tag, "resData",
            int'($signed(resData)), mAcc[0]);
      holdPrev = !mRun && !resReady && !actLoad;
    end
  end

  task automatic packActs();
    for (int i = 0; i < NE; i++) actData[i*AW +: AW] = curAct[i][AW-1:0];
  endtask

  // mode 0 random, 1 fixed value
  task automatic loadActs(input int mode, input int val, input bit holdWord);
    for (int i = 0; i < NE; i++)
      curAct[i] = (mode == 0) ? (int'($urandom % 256) - 128) : val;
    @(negedge clk);
    packActs();
    actLoad = 1'b1;
    if (holdWord) begin
      wValid = 1'b1; wData = 8'd121;
      for (int e = 0; e < LN; e++) curT[e] = 1;
    end
    @(negedge clk);
    actLoad = 1'b0;
    wValid = 1'b0;
  endtask

  task automatic sendWord(input logic [7:0] w, input int t [LN]);
    bit acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      if ($urandom % 4 == 0) begin
        wValid = 1'b0;
      end else begin
        wValid = 1'b1;
        wData = w;
        for (int e = 0; e < LN; e++) curT[e] = t[e];
        #1;
        acc = wReady;
      end
    end
  endtask

  task automatic genWord(input int mode, input int k, output logic [7:0] w, output int t [LN]);
    int code = 0;
    int pw = 1;
    for (int e = 0; e < LN; e++) t[e] = 0;
    if (mode == 2) begin
      if (k < 2 * LN) begin
        for (int e = 0; e < k / 2; e++) pw *= 3;
        code = (k % 2 == 1) ? 2 * pw : pw;
        t[k / 2] = (k % 2 == 1) ? -1 : 1;
      end
    end else if (mode == 3) begin
      code = 242;
      for (int e = 0; e < LN; e++) t[e] = -1;
    end else if (mode == 4) begin
      code = 121;
      for (int e = 0; e < LN; e++) t[e] = 1;
    end else if (mode == 1 && ($urandom % 2 == 0)) begin
      code = 243 + int'($urandom % 13);
    end else begin
      for (int e = 0; e < LN; e++) begin
        int d = int'($urandom % 3);
        t[e] = (d == 0) ? 0 : ((d == 1) ? 1 : -1);
        code += d * pw;
        pw *= 3;
      end
    end
    w = 8'(code);
  endtask

  task automatic sendPass(input int mode);
    for (int k = 0; k < PL; k++) begin
      logic [7:0] w;
      int t [LN];
      genWord(mode, k, w, t);
      sendWord(w, t);
    end
  endtask

  task automatic drainAll(input int abortAt);
    int got = 0;
    while (got < NE) begin
      @(negedge clk);
      wValid = 1'b0;
      if (got == abortAt) begin
        for (int i = 0; i < NE; i++) curAct[i] = int'($urandom % 256) - 128;
        packActs();
        actLoad = 1'b1;
        resReady = 1'b1;
        @(negedge clk);
        actLoad = 1'b0;
        resReady = 1'b0;
        return;
      end
      resReady = ($urandom % 3) != 0;
      #1;
      if (resValid && resReady) got++;
    end
    @(negedge clk);
    resReady = 1'b0;
  endtask

  task automatic runPass(input int mode);
    sendPass(mode);
    drainAll(-1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(wReady == 1'b1, "R1", "wReady", int'(wReady), 1);
    chk(resValid == 1'b0, "R1", "resValid", int'(resValid), 0);
    chk(done == 1'b0, "R1", "done", int'(done), 0);
    started = 1'b1;

    // R1: a pass with no load must return zeros
    tag = "R1"; runPass(0);

    tag = "R2"; loadActs(0, 0, 1'b0); runPass(2);
    tag = "R4"; loadActs(0, 0, 1'b0); runPass(0); runPass(0);
    tag = "R7"; runPass(0);
    tag = "R3"; loadActs(0, 0, 1'b0); runPass(1); runPass(1);
    tag = "R9"; loadActs(1, -128, 1'b0); runPass(3); runPass(4);
    loadActs(1, 127, 1'b0); runPass(4); runPass(3);

    tag = "R8";
    loadActs(0, 0, 1'b0);
    for (int k = 0; k < 5; k++) begin
      logic [7:0] w;
      int t [LN];
      genWord(0, k, w, t);
      sendWord(w, t);
    end
    loadActs(0, 0, 1'b1);
    runPass(0);
    sendPass(0);
    drainAll(3);
    runPass(0);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule